// File: doc/BRIEF.md
# Interleaved Two-Phase Pipelined Accumulator

This block keeps a wide running sum of an input stream, modulo 2^W, and gives the same result as a plain accumulator that adds one sample per cycle. It differs in how the loop is built. No adder closes in a single cycle. A feed-forward stage first adds each sample to the one before it. Two accumulator registers then take turns. Each register absorbs a pair sum only on its own phase, so its own sum from two cycles earlier is all it feeds back.

Because each feedback sum is needed again only two cycles later, every accumulator adder is cut in the middle. The lower half is added in one cycle. Its carry is registered and then added into the upper half in the next cycle. An output multiplexer follows the phase and registers whichever accumulator holds the newest complete sum. One running sum leaves the block every cycle, in order, a fixed four cycles after its last sample was accepted.

The input side is a valid/ready stream. The output side is a valid-only stream. The block never stalls: `in_ready` is always high. The output has no ready, so the consumer must take every beat flagged by `out_valid`. A synchronous clear restarts the sum from zero and drops any sums still in flight.

Top module: `ilv_accum`

## Requirements
- R1: Each output beat carries the sum, modulo 2^W, of every sample accepted since the last reset or clear, up to and including the sample it corresponds to. The first beat therefore equals the first sample.
- R2: A sample accepted at a rising edge (`in_valid` high) produces its `out_valid` beat exactly 4 rising edges later, i.e. it is visible just after the 4th edge. Beats come out in the order the samples were accepted.
- R3: A cycle with `in_valid` low adds nothing, whatever `in_data` holds, and produces no `out_valid` beat. The sum carries across any number of such idle cycles.
- R4: When `clr` is high at a rising edge, that cycle's sample is discarded and every sum in flight is dropped. `out_valid` is low after that edge. The first beat after the clear equals the first sample accepted after it.
- R5: The sum wraps at 2^W. Adding the all-ones value (-1 in two's complement) lowers the sum by one, so signed and unsigned samples share one datapath.
- R6: `in_ready` is high in every cycle, reset included. There is no back-pressure, and the output has no ready input.
- R7: A carry out of the lower W/2 bits reaches the upper bits of the same sum. Each accumulator's lower half changes only on its own phase, and the phase alternates every cycle unless a clear is applied.
- R8: After reset, `out_valid` and `out_data` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of the sum and pipeline |
| in_valid | input | 1 | Input sample is valid |
| in_ready | output | 1 | Always high; the block accepts every cycle |
| in_data | input | W (64) | Input sample, two's complement or unsigned |
| out_valid | output | 1 | Output beat is valid |
| out_data | output | W (64) | Running sum, modulo 2^W |

## Verification
Two events can land in the same cycle and are provoked together. The first is a clear arriving while valid samples are still inside the four-stage pipeline, with a valid, non-zero sample held on the input at that very edge. The bench drops its expected items at the clear. It then judges two things: that no stale beat ever appears, and that the first beat afterwards equals only the first new sample. The second pairing is a lower-half carry in one accumulator in the same cycle as the other accumulator's upper-half completion. This is provoked with back-to-back samples whose lower halves are all ones, and each resulting sum is compared against a single-cycle reference.

// File: rtl/ilv_accum_pkg.sv
package ilv_accum_pkg;

  // Cycles from an accepted sample to its output beat:
  // pair register, lower half, upper half, output register.
  localparam int PIPE_LAT = 4;

  typedef enum logic {
    PH_EVEN = 1'b0,
    PH_ODD  = 1'b1
  } phase_e;

  function automatic int lo_width(input int w);
    return w / 2;
  endfunction

endpackage

// File: rtl/ilv_pair_stage.sv
module ilv_pair_stage
  import ilv_accum_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         smp_vld,
  input  logic [W-1:0] smp,
  input  phase_e       phase,
  output logic [W-1:0] pair,
  output logic         pair_par
);

  logic [W-1:0] smp_z;
  logic [W-1:0] prev_q;

  // Idle cycles contribute zero.
  assign smp_z = smp_vld ? smp : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      pair     <= '0;
      pair_par <= 1'b0;
    end else if (clr) begin
      prev_q   <= '0;
      pair     <= '0;
      pair_par <= 1'b0;
    end else begin
      prev_q   <= smp_z;
      pair     <= prev_q + smp_z;
      pair_par <= logic'(phase);
    end
  end

endmodule

// File: rtl/ilv_split_acc.sv
module ilv_split_acc
  import ilv_accum_pkg::*;
#(
  parameter int   W   = 64,
  parameter logic IDX = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] pair,
  input  logic         pair_par,
  output logic [W-1:0] acc
);

  localparam int LO_W = lo_width(W);
  localparam int HI_W = W - LO_W;

  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;
  logic [HI_W-1:0] hi_add_q;
  logic            cy_q;
  logic            hi_go_q;
  logic            lo_go;
  logic [LO_W:0]   lo_sum;

  assign lo_go  = (pair_par == IDX);
  assign lo_sum = {1'b0, lo_q} + {1'b0, pair[LO_W-1:0]};

  // Lower half on own phase; upper half one cycle later with the carry.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q     <= '0;
      hi_q     <= '0;
      hi_add_q <= '0;
      cy_q     <= 1'b0;
      hi_go_q  <= 1'b0;
    end else if (clr) begin
      lo_q     <= '0;
      hi_q     <= '0;
      hi_add_q <= '0;
      cy_q     <= 1'b0;
      hi_go_q  <= 1'b0;
    end else begin
      hi_go_q <= lo_go;
      if (lo_go) begin
        lo_q     <= lo_sum[LO_W-1:0];
        cy_q     <= lo_sum[LO_W];
        hi_add_q <= pair[W-1:LO_W];
      end
      if (hi_go_q) begin
        hi_q <= hi_q + hi_add_q + HI_W'(cy_q);
      end
    end
  end

  assign acc = {hi_q, lo_q};

endmodule

// File: rtl/ilv_accum.sv
module ilv_accum
  import ilv_accum_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);

  phase_e              phase_q;
  logic [W-1:0]        pair_w;
  logic                par_w;
  logic [W-1:0]        acc_w [2];
  logic [PIPE_LAT-1:0] vld_sh;
  logic                rd_sel;

  assign in_ready = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   phase_q <= PH_EVEN;
    else if (clr) phase_q <= PH_EVEN;
    else          phase_q <= (phase_q == PH_EVEN) ? PH_ODD : PH_EVEN;
  end

  ilv_pair_stage #(.W(W)) u_pair (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .smp_vld  (in_valid),
    .smp      (in_data),
    .phase    (phase_q),
    .pair     (pair_w),
    .pair_par (par_w)
  );

  generate
    for (genvar k = 0; k < 2; k++) begin : g_acc
      ilv_split_acc #(.W(W), .IDX(k[0])) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .pair     (pair_w),
        .pair_par (par_w),
        .acc      (acc_w[k])
      );
    end
  endgenerate

  // The accumulator of the opposite phase holds the newest complete sum.
  assign rd_sel = ~logic'(phase_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
      vld_sh   <= '0;
    end else if (clr) begin
      out_data <= '0;
      vld_sh   <= '0;
    end else begin
      out_data <= acc_w[rd_sel];
      vld_sh   <= {vld_sh[PIPE_LAT-2:0], in_valid};
    end
  end

  assign out_valid = vld_sh[PIPE_LAT-1];

endmodule

// File: rtl/ilv_accum_chk.sv
module ilv_accum_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clr,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_data,
  input logic         out_valid,
  input logic [W-1:0] out_data,
  input logic         par,
  input logic         phase_b,
  input logic [W-1:0] acc0,
  input logic [W-1:0] acc1
);

  localparam int LO_W = W / 2;

  assert_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !out_valid);

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 4));

  assert_running_sum_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> out_data == $past(out_data) + $past(in_data, 4));

  assert_phase_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> phase_b != $past(phase_b));

  assert_acc0_lo_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (par && !clr) |=> $stable(acc0[LO_W-1:0]));

  assert_acc1_lo_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!par && !clr) |=> $stable(acc1[LO_W-1:0]));

endmodule

bind ilv_accum ilv_accum_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr       (clr),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_data  (out_data),
  .par       (par_w),
  .phase_b   (phase_q),
  .acc0      (acc_w[0]),
  .acc1      (acc_w[1])
);

// File: tb/ilv_accum_tb_top.sv
`timescale 1ns/1ps
module ilv_accum_tb_top;

  localparam int W   = 64;
  localparam int LAT = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clr = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_ready;
  logic         out_valid;
  logic [W-1:0] out_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  logic [W-1:0] ref_sum = '0;
  logic [W-1:0] exp_q [$];
  int           cyc_q [$];
  string        tag_q [$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ilv_accum #(.W(W)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: one beat per call, expected sum pushed to the scoreboard.
  task automatic send(input logic [W-1:0] x, input logic v, input string tag);
    @(negedge clk);
    check(in_ready == 1'b1, "R6 in_ready", W'(in_ready), W'(1));
    in_valid = v;
    in_data  = x;
    if (v) begin
      ref_sum = ref_sum + x;
      exp_q.push_back(ref_sum);
      cyc_q.push_back(cyc);
      tag_q.push_back(tag);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send(W'(64'hDEAD_BEEF_0BAD_F00D) ^ W'(i), 1'b0, "R3");
  endtask

  // Clear with a valid sample on the input and sums in flight (R4).
  task automatic do_clear();
    @(negedge clk);
    clr      = 1'b1;
    in_valid = 1'b1;
    in_data  = W'(64'h1234_5678_9ABC_DEF0);
    @(negedge clk);
    clr      = 1'b0;
    in_valid = 1'b0;
    exp_q.delete();
    cyc_q.delete();
    tag_q.delete();
    ref_sum = '0;
    check(out_valid == 1'b0, "R4 out_valid after clear", W'(out_valid), W'(0));
  endtask

  // Monitor.
  always @(negedge clk) begin
    if (rst_n && !clr && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected beat", out_data, '0);
      end else begin
        logic [W-1:0] e;
        int           c;
        string        t;
        e = exp_q.pop_front();
        c = cyc_q.pop_front();
        t = tag_q.pop_front();
        check(out_data == e, {t, " R1 sum"}, out_data, e);
        check((cyc - c) == LAT, "R2 latency", W'(cyc - c), W'(LAT));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8 out_valid in reset", W'(out_valid), '0);
    check(out_data == '0, "R8 out_data in reset", out_data, '0);
    check(in_ready == 1'b1, "R6 in_ready in reset", W'(in_ready), W'(1));
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 out_valid after reset", W'(out_valid), '0);

    // Small increments, back to back.
    for (int i = 1; i <= 20; i++) send(W'(i), 1'b1, "R1");
    // Bubbles with garbage data.
    send(W'(7), 1'b1, "R3");
    idle(3);
    send(W'(9), 1'b1, "R3");
    idle(1);
    send(W'(11), 1'b1, "R3");
    send(W'(13), 1'b1, "R3");
    idle(6);

    // Lower-half carry in both accumulators, back to back.
    for (int i = 0; i < 6; i++) send(W'(64'h0000_0000_FFFF_FFFF), 1'b1, "R7");
    send(W'(64'h0000_0000_0000_0001), 1'b1, "R7");
    // Wrap at 2^W and negative samples.
    send(W'(64'hFFFF_FFFF_FFFF_FFF0), 1'b1, "R5");
    send(W'(64'hFFFF_FFFF_FFFF_FFFF), 1'b1, "R5");
    send(W'(64'h8000_0000_0000_0000), 1'b1, "R5");
    send(W'(64'h8000_0000_0000_0000), 1'b1, "R5");
    send(W'(64'hFFFF_FFFF_FFFF_FFFF), 1'b1, "R5");
    idle(6);

    // Clear with sums in flight.
    send(W'(100), 1'b1, "R4");
    send(W'(200), 1'b1, "R4");
    send(W'(300), 1'b1, "R4");
    do_clear();
    send(W'(64'h0000_0042_0000_0005), 1'b1, "R4 first after clear");
    send(W'(3), 1'b1, "R4");
    idle(6);
    do_clear();
    idle(2);

    // Mixed random stream with random bubbles.
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] r;
      r = {$urandom(), $urandom()};
      send(r, ($urandom() % 4) != 0, "R1 random");
    end
    idle(8);

    check(exp_q.size() == 0, "R2 scoreboard drained", W'(exp_q.size()), '0);
    finish_run();
  end

endmodule